// File: doc/BRIEF.md
# Horizontal Sync Timing Generator

This block produces the horizontal sync waveform for a 640-pixel display line. It runs from a fast system clock and derives a pixel-rate tick internally by dividing that clock by a parameter (5 by default, giving 25 MHz from 125 MHz). Each line is one pass through three phases. The first is a high interval that covers active video and front porch. The second is a low sync pulse of 96 pixel periods. The third is a high back porch of 48 pixel periods. In the last system cycle of the back porch, a one-cycle line-end strobe tells the vertical timing logic to advance its line count.

The length of the first phase is programmable. While the generator is idle, a word N is written through a valid/value pair; it is stored and then reused for every line, so the high interval lasts N+1 pixel periods. N = 655 gives the standard line of 800 pixel periods. The generator holds still until its run enable is raised. This lets several timing generators start on the same cycle. Dropping the enable returns it to idle.

Top module: `hsync_gen`

## Requirements
- R1: During reset and directly after it, `hsync` is 1 and `line_end` is 0.
- R2: A value N on `load_value`, written with `load_valid` while idle, sets the first phase to N+1 pixel periods. With `run_en` driven high after such a load, the first falling edge of `hsync` comes 5·(N+1)+1 system cycles later, counted as samples taken once per cycle.
- R3: One pixel period is CLK_DIV (5) system cycles, and `hsync` is 0 for exactly 96 pixel periods (480 cycles) in every line.
- R4: Each sync pulse is followed by a 48-pixel high back porch and then the next first phase, so `hsync` stays high for 5·(N+1)+240 cycles between pulses. For N = 655 this is 704 pixel periods, and the period is 800.
- R5: `line_end` is high for exactly one system cycle per line, only while `hsync` is 1. That cycle is the 240th high cycle after the sync pulse ends (index 239 counted from 0), the final cycle of the back porch.
- R6: A `load_valid` pulse while the generator is running has no effect; the line timing keeps the stored value.
- R7: From the first clock edge at which `run_en` is sampled 0, `hsync` is 1 and `line_end` is 0, and they stay so while `run_en` remains 0.
- R8: When `load_valid` and the rising `run_en` fall in the same cycle, the newly presented value governs the first line.
- R9: Re-enabling without a new load starts a fresh line with the first phase and the value stored last.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (125 MHz nominal) |
| rst_n | input | 1 | Active-low synchronous reset |
| run_en | input | 1 | Start and keep running while high; idle while low |
| load_valid | input | 1 | Write strobe for the first-phase length, honoured only while idle |
| load_value | input | LOAD_W (10) | First-phase length minus one, in pixel periods |
| hsync | output | 1 | Horizontal sync, low during the sync pulse |
| line_end | output | 1 | One-cycle strobe in the last cycle of each line's back porch |

## Verification
The case that needs care is a new length arriving in the same cycle that the enable rises. The sequencer must leave idle and take its counter from the incoming word, not from the stored one. The bench drives both strobes on one falling edge and checks the delay to the first sync fall against the new value; it then re-enables without a load to confirm that the same word was also stored. A second coincidence is a disable that lands inside a sync pulse. That case is judged by `hsync` rising on the next edge with no line-end strobe.

// File: rtl/hsync_pkg.sv
package hsync_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_HIGH = 2'd1,
        PH_SYNC = 2'd2,
        PH_BACK = 2'd3
    } phase_e;

endpackage

// File: rtl/hsync_tick.sv
module hsync_tick #(
    parameter int CLK_DIV = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    output logic tick
);
    localparam int DIV_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
    localparam logic [DIV_W-1:0] LAST = DIV_W'(CLK_DIV - 1);

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
    } div_s;

    div_s div_d, div_q;

    always_comb begin
        div_d = div_q;
        if (clear || div_q.cnt == LAST) begin
            div_d.cnt = '0;
        end else begin
            div_d.cnt = div_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= '0;
        end else begin
            div_q <= div_d;
        end
    end

    assign tick = !clear && (div_q.cnt == LAST);
endmodule

// File: rtl/hsync_seq.sv
module hsync_seq
    import hsync_pkg::*;
#(
    parameter int LOAD_W   = 10,
    parameter int SYNC_LEN = 96,
    parameter int BACK_LEN = 48
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_en,
    input  logic              tick,
    input  logic              load_valid,
    input  logic [LOAD_W-1:0] load_value,
    output logic              idle,
    output logic [LOAD_W-1:0] cfg,
    output logic              hsync,
    output logic              line_end
);
    localparam int SPAN  = (SYNC_LEN > BACK_LEN) ? SYNC_LEN : BACK_LEN;
    localparam int SPAN_W = $clog2(SPAN);
    localparam int CNT_W = (LOAD_W > SPAN_W) ? LOAD_W : SPAN_W;
    localparam logic [CNT_W-1:0] SYNC_TOP = CNT_W'(SYNC_LEN - 1);
    localparam logic [CNT_W-1:0] BACK_TOP = CNT_W'(BACK_LEN - 1);

    typedef struct packed {
        phase_e            ph;
        logic [CNT_W-1:0]  cnt;
        logic [LOAD_W-1:0] len;
    } seq_s;

    seq_s seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        unique case (seq_q.ph)
            PH_IDLE: begin
                if (load_valid) begin
                    seq_d.len = load_value;
                end
                if (run_en) begin
                    seq_d.ph  = PH_HIGH;
                    seq_d.cnt = load_valid ? CNT_W'(load_value) : CNT_W'(seq_q.len);
                end
            end
            PH_HIGH: begin
                if (tick) begin
                    if (seq_q.cnt == '0) begin
                        seq_d.ph  = PH_SYNC;
                        seq_d.cnt = SYNC_TOP;
                    end else begin
                        seq_d.cnt = seq_q.cnt - 1'b1;
                    end
                end
            end
            PH_SYNC: begin
                if (tick) begin
                    if (seq_q.cnt == '0) begin
                        seq_d.ph  = PH_BACK;
                        seq_d.cnt = BACK_TOP;
                    end else begin
                        seq_d.cnt = seq_q.cnt - 1'b1;
                    end
                end
            end
            PH_BACK: begin
                if (tick) begin
                    if (seq_q.cnt == '0) begin
                        seq_d.ph  = PH_HIGH;
                        seq_d.cnt = CNT_W'(seq_q.len);
                    end else begin
                        seq_d.cnt = seq_q.cnt - 1'b1;
                    end
                end
            end
            default: seq_d.ph = PH_IDLE;
        endcase
        if (!run_en && seq_q.ph != PH_IDLE) begin
            seq_d.ph  = PH_IDLE;
            seq_d.cnt = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q <= '{ph: PH_IDLE, cnt: '0, len: '0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign idle     = (seq_q.ph == PH_IDLE);
    assign cfg      = seq_q.len;
    assign hsync    = (seq_q.ph != PH_SYNC);
    assign line_end = run_en && tick && (seq_q.ph == PH_BACK) && (seq_q.cnt == '0);
endmodule

// File: rtl/hsync_gen.sv
module hsync_gen #(
    parameter int CLK_DIV  = 5,
    parameter int LOAD_W   = 10,
    parameter int SYNC_LEN = 96,
    parameter int BACK_LEN = 48
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_en,
    input  logic              load_valid,
    input  logic [LOAD_W-1:0] load_value,
    output logic              hsync,
    output logic              line_end
);
    logic              pix_tick;
    logic              seq_idle;
    logic [LOAD_W-1:0] cfg_val;

    hsync_tick #(.CLK_DIV(CLK_DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (seq_idle),
        .tick  (pix_tick)
    );

    hsync_seq #(
        .LOAD_W   (LOAD_W),
        .SYNC_LEN (SYNC_LEN),
        .BACK_LEN (BACK_LEN)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_en     (run_en),
        .tick       (pix_tick),
        .load_valid (load_valid),
        .load_value (load_value),
        .idle       (seq_idle),
        .cfg        (cfg_val),
        .hsync      (hsync),
        .line_end   (line_end)
    );
endmodule

// File: rtl/hsync_gen_chk.sv
module hsync_gen_chk #(
    parameter int CLK_DIV  = 5,
    parameter int LOAD_W   = 10,
    parameter int SYNC_LEN = 96
) (
    input logic              clk,
    input logic              rst_n,
    input logic              run_en,
    input logic              load_valid,
    input logic              seq_idle,
    input logic [LOAD_W-1:0] cfg_val,
    input logic              hsync,
    input logic              line_end
);
    localparam int LOW_CYC = SYNC_LEN * CLK_DIV;

    logic [15:0] low_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n || hsync) begin
            low_cnt <= '0;
        end else begin
            low_cnt <= low_cnt + 1'b1;
        end
    end

    // R3: a completed sync pulse lasts SYNC_LEN pixel periods
    a_r3_sync_width: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(hsync) && $past(run_en)) |-> (low_cnt == 16'(LOW_CYC)));

    // R5: line-end strobe is a single cycle
    a_r5_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        line_end |=> !line_end);

    // R5: line-end strobe falls in a high part of the line
    a_r5_strobe_high: assert property (@(posedge clk) disable iff (!rst_n)
        line_end |-> hsync);

    // R6: stored length does not move while running
    a_r6_no_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (!seq_idle && load_valid) |=> $stable(cfg_val));

    // R7: disabled generator is quiet from the next edge
    a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> (hsync && !line_end));
endmodule

bind hsync_gen hsync_gen_chk #(
    .CLK_DIV  (CLK_DIV),
    .LOAD_W   (LOAD_W),
    .SYNC_LEN (SYNC_LEN)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .run_en     (run_en),
    .load_valid (load_valid),
    .seq_idle   (seq_idle),
    .cfg_val    (cfg_val),
    .hsync      (hsync),
    .line_end   (line_end)
);

// File: tb/sim_hsync_gen.sv
module sim_hsync_gen;
    localparam int CLK_PERIOD = 8;
    localparam int DIV = 5;
    localparam int SYNC_CYC = 96 * DIV;
    localparam int BACK_CYC = 48 * DIV;
    localparam int WATCHDOG = 150000;
    localparam int NVEC = 4;
    localparam int LOADS [NVEC] = '{655, 3, 0, 100};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       run_en = 1'b0;
    logic       load_valid = 1'b0;
    logic [9:0] load_value = '0;
    logic       hsync;
    logic       line_end;

    int checks = 0;
    int fails = 0;
    int cycles = 0;

    hsync_gen u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_en     (run_en),
        .load_valid (load_valid),
        .load_value (load_value),
        .hsync      (hsync),
        .line_end   (line_end)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles == WATCHDOG) begin
            fails = fails + 1;
            $display("FAIL watchdog: actual=%0d cycles expected<%0d", cycles, WATCHDOG);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic load_word(input int n);
        load_value = 10'(n);
        load_valid = 1'b1;
        @(negedge clk);
        load_valid = 1'b0;
    endtask

    // count samples from the current negedge until hsync first reads 0
    task automatic time_to_fall(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (hsync);
    endtask

    // entered on a sample where hsync is 0 (first low cycle of a line's pulse)
    task automatic measure_line(output int lo, output int hi, output int ne, output int pos);
        lo = 1; hi = 0; ne = 0; pos = -1;
        forever begin
            @(negedge clk);
            if (hsync) break;
            lo++;
        end
        forever begin
            if (!hsync) break;
            if (line_end) begin
                ne++;
                pos = hi;
            end
            hi++;
            @(negedge clk);
        end
    endtask

    initial begin
        int lo, hi, ne, pos, t;
        @(negedge clk);
        // R1: reset state
        check("R1 hsync in reset", int'(hsync), 1);
        check("R1 line_end in reset", int'(line_end), 0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 hsync after reset", int'(hsync), 1);
        check("R1 line_end after reset", int'(line_end), 0);

        // table walk: R2, R3, R4, R5
        for (int v = 0; v < NVEC; v++) begin
            run_en = 1'b0;
            repeat (4) @(negedge clk);
            load_word(LOADS[v]);
            run_en = 1'b1;
            time_to_fall(t);
            check("R2 first phase length", t, DIV * (LOADS[v] + 1) + 1);
            for (int l = 0; l < 2; l++) begin
                measure_line(lo, hi, ne, pos);
                check("R3 sync low width", lo, SYNC_CYC);
                check("R4 high width", hi, DIV * (LOADS[v] + 1) + BACK_CYC);
                check("R5 strobes per line", ne, 1);
                check("R5 strobe position", pos, BACK_CYC - 1);
            end
        end

        // R4: standard line figures in pixel periods
        run_en = 1'b0;
        repeat (3) @(negedge clk);
        load_word(655);
        run_en = 1'b1;
        time_to_fall(t);
        measure_line(lo, hi, ne, pos);
        check("R4 high pixels", hi / DIV, 704);
        check("R4 period pixels", (hi + lo) / DIV, 800);

        // R6: load while running is ignored
        repeat (50) @(negedge clk);
        load_word(10);
        time_to_fall(t);
        measure_line(lo, hi, ne, pos);
        check("R6 high width after running load", hi, DIV * 656 + BACK_CYC);
        measure_line(lo, hi, ne, pos);
        check("R6 high width second line", hi, DIV * 656 + BACK_CYC);

        // R7: disable inside a sync pulse
        repeat (100) @(negedge clk);
        check("R7 inside pulse", int'(hsync), 0);
        run_en = 1'b0;
        @(negedge clk);
        check("R7 hsync after disable", int'(hsync), 1);
        ne = 0; lo = 0;
        for (int i = 0; i < 60; i++) begin
            if (line_end) ne++;
            if (!hsync) lo++;
            @(negedge clk);
        end
        check("R7 no strobe while idle", ne, 0);
        check("R7 no low while idle", lo, 0);

        // R8: load and enable in the same cycle
        load_value = 10'd20;
        load_valid = 1'b1;
        run_en = 1'b1;
        @(negedge clk);
        load_valid = 1'b0;
        t = 1;
        while (hsync) begin
            @(negedge clk);
            t++;
        end
        check("R8 coincident load length", t, DIV * 21 + 1);

        // R9: re-enable without load reuses stored value
        run_en = 1'b0;
        repeat (5) @(negedge clk);
        run_en = 1'b1;
        time_to_fall(t);
        check("R9 stored value reused", t, DIV * 21 + 1);
        measure_line(lo, hi, ne, pos);
        check("R9 line high width", hi, DIV * 21 + BACK_CYC);

        // R1: reset while running
        repeat (20) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 hsync on mid-run reset", int'(hsync), 1);
        check("R1 line_end on mid-run reset", int'(line_end), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule